// File: doc/BRIEF.md
# Scaled-Counter Multi-Channel PWM Timer

This block is a register-mapped pulse-width timer. A 31-bit counter advances once per clock while enabled. A programmable right shift of 0 to 15 bits reduces it to a 16-bit scaled count. Four compare lanes each hold a 16-bit threshold. A lane drives its output low while the scaled count is at or above its nonzero threshold. Because the shift sets the period, a period lasts 2^(16+scale) clocks unless the counter is told to restart on a match with compare lane 0. No threshold keeps an output low for the whole period, and a threshold of zero keeps the lane off.

Counting is run by a three-state controller. In `RUN_IDLE` the counter holds. In `RUN_FREE` it counts without end. In `RUN_ONCE` it counts through one period and then drops back to `RUN_IDLE` by itself. The transitions are as follows. A configuration write with bit 12 set goes to `RUN_FREE`. A write with bit 13 set and bit 12 clear goes to `RUN_ONCE`. A write with both bits clear goes to `RUN_IDLE`. In `RUN_ONCE`, the counter wrap returns the controller to `RUN_IDLE`. Each lane also raises a pending flag when its condition turns true, and software clears that flag.

The bus is a single-cycle valid/write/address/data port. Writes take effect at the clock edge. Read data follows the address with no delay. All writes act at once, with no shadow copies, so one period may mix a new scale with an old threshold.

Top module: `scaled_pwm_timer`

## Requirements
- R1: After reset, every readable register reads 0, all four `pwm_out_n` pins are high, and `irq` is 0.
- R2: The register map is as follows. Configuration is at 0x00. The raw 31-bit count is at 0x08 and can be read and written. The scaled count is at 0x10 and is read-only. Compare lane n is at 0x20+4n and is 16 bits wide. Configuration bits other than [3:0], 9, 12, 13 and [31:28] read as 0, whatever was written to them.
- R3: The scaled count equals count bits [scale+15:scale], where scale is configuration bits [3:0]. A new scale shows up in the scaled count at once.
- R4: While the controller is in `RUN_FREE` (configuration bit 12), the count rises by one each clock. After a write that clears both enable bits, the count holds.
- R5: The count returns to 0 on the clock after it reaches 2^(16+scale)-1.
- R6: Setting bit 13 alone makes bit 13 read 1 and runs one period. On the wrap clock, bit 13 reads 0 and the count stays at 0.
- R7: When configuration bit 9 is set and the counter is running, the clock after the scaled count equals compare lane 0 brings the count back to 0.
- R8: `pwm_out_n[n]` is low exactly when compare n is nonzero and the scaled count is at or above compare n. The pin follows the current count and the current compare value without delay.
- R9: The pending flag for lane n is configuration bit 28+n and also appears on `irq[n]`. It sets on the clock after lane n's condition turns true. A configuration write with 0 in that bit clears it. A write with 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out_n | output | 4 | Active-low lane outputs |
| irq | output | 4 | Per-lane pending flags |

## Verification
A wrong controller state shows at the ports within one clock. A held or running count shows as a frozen or moving value at 0x08. A one-shot that never ends leaves bit 13 reading 1 after the wrap. A wrong counter wrap appears on the edge that follows 2^(16+scale)-1, or the edge after a lane-0 match, as a count other than zero. A stale or missing lane-condition register is visible one clock after the threshold is crossed, as a pending flag that stays clear or sets twice.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_FREE = 2'd1,
        RUN_ONCE = 2'd2
    } run_state_e;

    localparam logic [7:0] OFS_CFG    = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h08;
    localparam logic [7:0] OFS_SCALED = 8'h10;
    localparam logic [7:0] OFS_CMP0   = 8'h20;

    localparam int BIT_ZERO_MODE = 9;
    localparam int BIT_EN_FREE   = 12;
    localparam int BIT_EN_ONCE   = 13;
    localparam int BIT_FLAG0     = 28;

endpackage

// File: rtl/pwm_count_core.sv
module pwm_count_core
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SCALE_W-1:0] scale,
    input  logic               zero_mode,
    input  logic [CMP_W-1:0]   cmp0,
    input  logic               cfg_we,
    input  logic               en_free,
    input  logic               en_once,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   cnt_wdata,
    output logic [CNT_W-1:0]   count,
    output logic [CMP_W-1:0]   scaled,
    output logic               run_free,
    output logic               run_once
);

    localparam int EXT_W = CNT_W + CMP_W;
    localparam int IDX_W = $clog2(EXT_W);
    localparam int SH_W  = $clog2(CNT_W + CMP_W + 1);

    run_state_e state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [EXT_W-1:0] ext;
    logic [SH_W-1:0]  shamt;
    logic [CNT_W-1:0] period_mask;
    logic running, period_end, zero_match, wrap;

    // scaled view of the counter
    always_comb begin
        ext    = {{CMP_W{1'b0}}, count_q};
        scaled = ext[IDX_W'(scale) +: CMP_W];
    end

    always_comb begin
        shamt       = SH_W'(CMP_W) + SH_W'(scale);
        period_mask = ~({CNT_W{1'b1}} << shamt);
        running     = (state_q != RUN_IDLE);
        period_end  = ((count_q & period_mask) == period_mask);
        zero_match  = zero_mode && (scaled == cmp0);
        wrap        = running && (period_end || zero_match);
    end

    // controller state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    // controller transitions
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            if (en_free)      state_d = RUN_FREE;
            else if (en_once) state_d = RUN_ONCE;
            else              state_d = RUN_IDLE;
        end else begin
            unique case (state_q)
                RUN_IDLE: state_d = RUN_IDLE;
                RUN_FREE: state_d = RUN_FREE;
                RUN_ONCE: state_d = wrap ? RUN_IDLE : RUN_ONCE;
                default:  state_d = RUN_IDLE;
            endcase
        end
    end

    // counter datapath
    always_comb begin
        if (cnt_we)       count_d = cnt_wdata;
        else if (wrap)    count_d = '0;
        else if (running) count_d = (count_q + 1'b1) & period_mask;
        else              count_d = count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // outputs decoded from the state
    always_comb begin
        count    = count_q;
        run_free = (state_q == RUN_FREE);
        run_once = (state_q == RUN_ONCE);
    end

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_IDLE && !cnt_we) |=> $stable(count_q));

    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (running && period_end && !cnt_we) |=> (count_q == '0));

    a_r7_zero_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (running && zero_mode && scaled == cmp0 && !cnt_we) |=> (count_q == '0));

    a_r6_once_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_ONCE && wrap && !cfg_we) |=> (state_q == RUN_IDLE));

endmodule

// File: rtl/pwm_compare_lane.sv
module pwm_compare_lane #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_we,
    input  logic [CMP_W-1:0] cmp_wdata,
    input  logic [CMP_W-1:0] scaled,
    input  logic             flag_wr,
    input  logic             flag_wbit,
    output logic [CMP_W-1:0] cmp,
    output logic             out_n,
    output logic             flag
);

    logic [CMP_W-1:0] cmp_q;
    logic cond, cond_q, flag_q, rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    always_comb begin
        cond = (cmp_q != '0) && (scaled >= cmp_q);
        rise = cond && !cond_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            cond_q <= cond;
            flag_q <= (flag_q && !(flag_wr && !flag_wbit)) || rise;
        end
    end

    always_comb begin
        cmp   = cmp_q;
        out_n = ~cond;
        flag  = flag_q;
    end

    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && !cond_q) |=> flag_q);

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wbit && !(cond && !cond_q)) |=> !flag_q);

endmodule

// File: rtl/scaled_pwm_timer.sv
module scaled_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out_n,
    output logic [NUM_CH-1:0] irq
);

    localparam int STRIDE = 4;

    logic wr;
    logic cfg_we, cnt_we;
    logic [SCALE_W-1:0] scale_q;
    logic zero_mode_q;
    logic [CNT_W-1:0] count;
    logic [CMP_W-1:0] scaled;
    logic run_free, run_once;
    logic [NUM_CH-1:0] cmp_we;
    logic [CMP_W-1:0] cmp_val [NUM_CH];

    always_comb begin
        wr     = bus_valid && bus_write;
        cfg_we = wr && (bus_addr == OFS_CFG);
        cnt_we = wr && (bus_addr == OFS_COUNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_q     <= '0;
            zero_mode_q <= 1'b0;
        end else if (cfg_we) begin
            scale_q     <= bus_wdata[SCALE_W-1:0];
            zero_mode_q <= bus_wdata[BIT_ZERO_MODE];
        end
    end

    pwm_count_core #(
        .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .scale(scale_q), .zero_mode(zero_mode_q), .cmp0(cmp_val[0]),
        .cfg_we(cfg_we),
        .en_free(bus_wdata[BIT_EN_FREE]), .en_once(bus_wdata[BIT_EN_ONCE]),
        .cnt_we(cnt_we), .cnt_wdata(bus_wdata[CNT_W-1:0]),
        .count(count), .scaled(scaled),
        .run_free(run_free), .run_once(run_once)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
        assign cmp_we[n] = wr && (bus_addr == OFS_CMP0 + 8'(STRIDE * n));

        pwm_compare_lane #(.CMP_W(CMP_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .cmp_we(cmp_we[n]), .cmp_wdata(bus_wdata[CMP_W-1:0]),
            .scaled(scaled),
            .flag_wr(cfg_we), .flag_wbit(bus_wdata[BIT_FLAG0 + n]),
            .cmp(cmp_val[n]), .out_n(pwm_out_n[n]), .flag(irq[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CFG) begin
            bus_rdata[SCALE_W-1:0]                 = scale_q;
            bus_rdata[BIT_ZERO_MODE]               = zero_mode_q;
            bus_rdata[BIT_EN_FREE]                 = run_free;
            bus_rdata[BIT_EN_ONCE]                 = run_once;
            bus_rdata[BIT_FLAG0 +: NUM_CH]         = irq;
        end else if (bus_addr == OFS_COUNT) begin
            bus_rdata[CNT_W-1:0] = count;
        end else if (bus_addr == OFS_SCALED) begin
            bus_rdata[CMP_W-1:0] = scaled;
        end else begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (bus_addr == OFS_CMP0 + 8'(STRIDE * n))
                    bus_rdata[CMP_W-1:0] = cmp_val[n];
            end
        end
    end

    a_r8_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_val[0] == '0) |-> pwm_out_n[0]);

endmodule

// File: tb/scaled_pwm_timer_test.sv
module scaled_pwm_timer_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0] pwm_out_n, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    scaled_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out_n(pwm_out_n), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic test_reset;
        logic [31:0] v;
        rd(8'h00, v); check("R1 cfg", v, 0);
        rd(8'h08, v); check("R1 count", v, 0);
        rd(8'h20, v); check("R1 cmp0", v, 0);
        check("R1 outputs", {28'd0, pwm_out_n}, 32'hF);
        check("R1 irq", {28'd0, irq}, 0);
    endtask

    task automatic test_map_scale;
        logic [31:0] v;
        wr(8'h00, 32'h0101_0503);
        rd(8'h00, v); check("R2 unimplemented bits zero", v, 32'h3);
        wr(8'h2C, 32'h0001_ABCD);
        rd(8'h2C, v); check("R2 cmp3 width", v, 32'hABCD);
        wr(8'h2C, 0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); check("R2 count width", v, 32'h7FFF_FFFF);
        wr(8'h08, 32'h0001_2345);
        wr(8'h00, 32'h4);
        rd(8'h10, v); check("R3 scale4", v, 32'h1234);
        wr(8'h00, 32'h0);
        rd(8'h10, v); check("R3 scale0", v, 32'h2345);
        wr(8'h00, 32'hF);
        rd(8'h10, v); check("R3 scale15", v, 32'h2);
        wr(8'h00, 32'h0);
    endtask

    task automatic test_free_run;
        logic [31:0] v;
        wr(8'h08, 100);
        wr(8'h00, 32'h1000);
        rd(8'h00, v); check("R4 free bit", v, 32'h1000);
        rd(8'h08, v); check("R4 start", v, 100);
        tick(10);
        rd(8'h08, v); check("R4 after 10", v, 110);
        wr(8'h00, 0);
        rd(8'h08, v); check("R4 stop", v, 111);
        tick(5);
        rd(8'h08, v); check("R4 hold", v, 111);
    endtask

    task automatic test_wrap;
        logic [31:0] v;
        wr(8'h08, 32'hFFFE);
        wr(8'h00, 32'h1000);
        tick(1);
        rd(8'h08, v); check("R5 top scale0", v, 32'hFFFF);
        tick(1);
        rd(8'h08, v); check("R5 wrap scale0", v, 0);
        wr(8'h00, 0);
        wr(8'h08, 32'hFFFF);
        wr(8'h00, 32'h1001);
        tick(1);
        rd(8'h08, v); check("R5 no wrap scale1", v, 32'h10000);
        wr(8'h00, 0);
        wr(8'h08, 32'h1FFFF);
        wr(8'h00, 32'h1001);
        tick(1);
        rd(8'h08, v); check("R5 wrap scale1", v, 0);
        wr(8'h00, 0);
    endtask

    task automatic test_once;
        logic [31:0] v;
        wr(8'h08, 32'hFFFD);
        wr(8'h00, 32'h2000);
        rd(8'h00, v); check("R6 once bit set", v, 32'h2000);
        tick(2);
        rd(8'h08, v); check("R6 counting", v, 32'hFFFF);
        tick(1);
        rd(8'h08, v); check("R6 wrapped", v, 0);
        rd(8'h00, v); check("R6 once bit clear", v, 0);
        tick(5);
        rd(8'h08, v); check("R6 stays stopped", v, 0);
    endtask

    task automatic test_zero_mode;
        logic [31:0] v;
        wr(8'h20, 5);
        wr(8'h08, 0);
        wr(8'h00, 32'h1200);
        tick(5);
        rd(8'h08, v); check("R7 at match", v, 5);
        check("R8 lane0 low at match", {31'd0, pwm_out_n[0]}, 0);
        tick(1);
        rd(8'h08, v); check("R7 restart", v, 0);
        check("R8 lane0 high after restart", {31'd0, pwm_out_n[0]}, 1);
        wr(8'h00, 0);
        wr(8'h20, 0);
    endtask

    task automatic test_compare;
        wr(8'h24, 32'h10);
        wr(8'h08, 32'h0F);
        check("R8 below", {31'd0, pwm_out_n[1]}, 1);
        wr(8'h08, 32'h10);
        check("R8 equal", {31'd0, pwm_out_n[1]}, 0);
        wr(8'h08, 32'hFFFF);
        check("R8 top", {31'd0, pwm_out_n[1]}, 0);
        check("R8 zero compare off", {31'd0, pwm_out_n[0]}, 1);
        wr(8'h28, 32'hFFFF);
        check("R8 max compare at top", {31'd0, pwm_out_n[2]}, 0);
        wr(8'h08, 32'hFFFE);
        check("R8 max compare below top", {31'd0, pwm_out_n[2]}, 1);
        wr(8'h24, 32'hFFFF);
        check("R8 compare write immediate", {31'd0, pwm_out_n[1]}, 1);
        wr(8'h00, 32'h2);
        check("R3 scale change moves output", {31'd0, pwm_out_n[1]}, 1);
        wr(8'h00, 0);
    endtask

    task automatic test_flags;
        logic [31:0] v;
        wr(8'h28, 32'h20);
        wr(8'h08, 32'h1E);
        wr(8'h00, 0);
        tick(1);
        check("R9 clear start", {31'd0, irq[2]}, 0);
        wr(8'h08, 32'h20);
        check("R9 not yet", {31'd0, irq[2]}, 0);
        tick(1);
        check("R9 set", {31'd0, irq[2]}, 1);
        rd(8'h00, v); check("R9 cfg bit30", {31'd0, v[30]}, 1);
        wr(8'h00, 32'h4000_0000);
        check("R9 write one keeps", {31'd0, irq[2]}, 1);
        wr(8'h00, 0);
        check("R9 write zero clears", {31'd0, irq[2]}, 0);
        tick(3);
        check("R9 stays clear", {31'd0, irq[2]}, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        test_reset();
        test_map_scale();
        test_free_run();
        test_wrap();
        test_once();
        test_zero_mode();
        test_compare();
        test_flags();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule